// File: doc/BRIEF.md
# Receiver Enable and Soft-Reset Controller

This block is the control front end of a packet receiver. It holds a small memory-mapped register set behind a simple single-cycle write port and a combinational read port. The configuration word carries a run-enable bit and a soft-reset bit. Software uses them to stop the receiver, either with the lanes powered down (enable cleared) or with the lanes left up (soft reset held).

Whenever the receiver enters a halted state, the block pulses a flush strobe to each of the three internal FIFOs: lane interface, packet and generic short packet. It also ends any packet that is part-way through. Such a packet is not dropped. The block emits one closing beat on its AXI4-Stream output with the last flag and an error flag in the user field, so the consumer sees a closed, errored packet. Two FIFO-full status levels arrive from the core clock domain and reach the register domain through two-flop synchronizers.

The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `rx_enable_ctrl`

## Requirements
- R1: After reset, offset 0x00 reads 0x1, offsets 0x04, 0x20 and 0x28 read 0, offset 0x08 reads 0x10, and `lane_shutdown_o`, `flush_o` and `m_tvalid` are 0.
- R2: Register fields read back what was written: lane count at 0x04 bits [1:0], packet setup at 0x08 bits [7:0], global interrupt gate at 0x20 bit 0, interrupt mask at 0x28 bits [1:0]. Bits outside a field read 0, and offset 0x10 is read-only.
- R3: At offset 0x00, bit 0 is run enable and bit 1 is soft reset. Bits 31 to 2 read 0 and ignore writes.
- R4: While soft reset is 1, offset 0x08 reads its default 0x10 and ignores writes. Enable, soft reset, 0x04, 0x20 and 0x28 keep their values and still accept writes.
- R5: Writing 0 to bit 1 of 0x00 (with bit 0 at 1) ends soft reset. Offset 0x08 becomes writable again and input beats are accepted in the cycle after the write.
- R6: `lane_shutdown_o` is 1 exactly when run enable is 0, from the cycle after the write. Soft reset leaves it at 0.
- R7: When the receiver goes from running to halted (enable 0 or soft reset 1), all three `flush_o` bits are 1 for exactly the one cycle after the write. No strobe fires if the receiver was already halted.
- R8: If the receiver halts while a packet is open (first beat accepted, last not yet accepted), one closing beat follows with `m_tdata` 0, `m_tlast` 1 and `m_tuser` 2'b10. It is held until `m_tready` is 1.
- R9: While halted, `in_ready` is 0 and no input beat is forwarded, until enable is 1 and soft reset is 0.
- R10: While running, input beats pass to the output in the same cycle, with `in_ready` equal to `m_tready`. `m_tuser[0]` is 1 on the first beat of a packet and 0 on later beats, and `m_tuser[1]` is 0.
- R11: Offset 0x10 bit 0 shows `short_full_i` and bit 1 shows `line_full_i`, each through two flops. A change is visible after the second rising edge.
- R12: Offsets outside the register map read 0.
- R13: Halting with no packet open produces no closing beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and packet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (8) | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| short_full_i | input | 1 | Short packet FIFO full, core clock domain |
| line_full_i | input | 1 | Line buffer FIFO full, core clock domain |
| lane_shutdown_o | output | 1 | Lane shutdown request |
| flush_o | output | NUM_FIFO (3) | Flush strobes: bit 0 lane FIFO, bit 1 packet FIFO, bit 2 short packet FIFO |
| in_valid | input | 1 | Input beat valid |
| in_data | input | TDATA_W (32) | Input beat data |
| in_last | input | 1 | Input beat ends packet |
| in_ready | output | 1 | Input beat accepted |
| m_tvalid | output | 1 | AXI4-Stream valid |
| m_tdata | output | TDATA_W (32) | AXI4-Stream data |
| m_tlast | output | 1 | AXI4-Stream last |
| m_tuser | output | 2 | Bit 0 first beat, bit 1 errored packet |
| m_tready | input | 1 | AXI4-Stream ready |

## Verification
The halt function is driven four ways:
- Soft reset while a packet is open and the consumer stalls. This separates the closing-beat path and its hold from plain blocking.
- Disable while idle. This shows that shutdown and flush come from the enable bit alone and that no closing beat appears.
- Soft reset on top of an already disabled receiver. This shows that the flush strobe fires only on entry to the halted state.
- Release of soft reset. This shows that held-default and preserved registers are told apart, and that input acceptance resumes.

Register write patterns with all ones separate each field's width from the reserved bits. The status inputs are stepped to show the two-edge delay.

// File: rtl/rxctl_pkg.sv
package rxctl_pkg;
  // register offsets, bytes
  localparam int OFF_CFG   = 'h00;
  localparam int OFF_LANES = 'h04;
  localparam int OFF_PCFG  = 'h08;
  localparam int OFF_STAT  = 'h10;
  localparam int OFF_GIE   = 'h20;
  localparam int OFF_IER   = 'h28;

  localparam int LANE_W = 2;
  localparam int STAT_W = 2;
  localparam int REG_W  = 32;

  typedef enum logic [1:0] {
    PK_IDLE  = 2'd0,
    PK_BUSY  = 2'd1,
    PK_CLOSE = 2'd2
  } pk_state_t;
endpackage

// File: rtl/rxctl_sync.sv
module rxctl_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // one pair of flops per level bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= d[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/rxctl_regs.sv
module rxctl_regs
  import rxctl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              PCFG_W   = 8,
  parameter logic [PCFG_W-1:0] PCFG_RST = 8'h10,
  parameter int              IER_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [STAT_W-1:0] stat,
  output logic              run_en,
  output logic              soft_rst
);
  logic              en_q, en_d;
  logic              sr_q, sr_d;
  logic [LANE_W-1:0] lanes_q, lanes_d;
  logic [PCFG_W-1:0] pcfg_q, pcfg_d;
  logic              gie_q, gie_d;
  logic [IER_W-1:0]  ier_q, ier_d;
  logic              reg_ce;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  // next-state
  always_comb begin
    en_d    = en_q;
    sr_d    = sr_q;
    lanes_d = lanes_q;
    pcfg_d  = pcfg_q;
    gie_d   = gie_q;
    ier_d   = ier_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(OFF_CFG): begin
          en_d = wdata[0];
          sr_d = wdata[1];
        end
        ADDR_W'(OFF_LANES): lanes_d = wdata[LANE_W-1:0];
        ADDR_W'(OFF_PCFG):  pcfg_d  = wdata[PCFG_W-1:0];
        ADDR_W'(OFF_GIE):   gie_d   = wdata[0];
        ADDR_W'(OFF_IER):   ier_d   = wdata[IER_W-1:0];
        default: ;
      endcase
    end
    // soft reset pins the clearable registers at their defaults
    if (sr_q) begin
      pcfg_d = PCFG_RST;
    end
  end

  assign reg_ce = wr_en | sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      sr_q    <= 1'b0;
      lanes_q <= '0;
      pcfg_q  <= PCFG_RST;
      gie_q   <= 1'b0;
      ier_q   <= '0;
    end else if (reg_ce) begin
      en_q    <= en_d;
      sr_q    <= sr_d;
      lanes_q <= lanes_d;
      pcfg_q  <= pcfg_d;
      gie_q   <= gie_d;
      ier_q   <= ier_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_CFG): begin
        rdata[0] = en_q;
        rdata[1] = sr_q;
      end
      ADDR_W'(OFF_LANES): rdata[LANE_W-1:0] = lanes_q;
      ADDR_W'(OFF_PCFG):  rdata[PCFG_W-1:0] = pcfg_q;
      ADDR_W'(OFF_STAT):  rdata[STAT_W-1:0] = stat;
      ADDR_W'(OFF_GIE):   rdata[0]          = gie_q;
      ADDR_W'(OFF_IER):   rdata[IER_W-1:0]  = ier_q;
      default: ;
    endcase
  end

  assign run_en   = en_q;
  assign soft_rst = sr_q;
endmodule

// File: rtl/rxctl_flush.sv
module rxctl_flush #(
  parameter int NUM_FIFO = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt,
  output logic [NUM_FIFO-1:0] flush
);
  logic halt_q;
  logic halt_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt;
    end
  end

  assign halt_rise = halt & ~halt_q;

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    assign flush[i] = halt_rise;
  end
endmodule

// File: rtl/rxctl_pkt.sv
module rxctl_pkt
  import rxctl_pkg::*;
#(
  parameter int TDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt,
  input  logic               in_valid,
  input  logic [TDATA_W-1:0] in_data,
  input  logic               in_last,
  output logic               in_ready,
  output logic               m_tvalid,
  output logic [TDATA_W-1:0] m_tdata,
  output logic               m_tlast,
  output logic [1:0]         m_tuser,
  input  logic               m_tready
);
  pk_state_t state_q, state_d;
  logic      pass;
  logic      take;

  assign pass = ~halt & (state_q != PK_CLOSE);
  assign take = pass & in_valid & m_tready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PK_IDLE:  if (take && !in_last) state_d = PK_BUSY;
      PK_BUSY: begin
        if (halt)                 state_d = PK_CLOSE;
        else if (take && in_last) state_d = PK_IDLE;
      end
      PK_CLOSE: if (m_tready)     state_d = PK_IDLE;
      default:                    state_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PK_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    in_ready = pass & m_tready;
    if (state_q == PK_CLOSE) begin
      m_tvalid = 1'b1;
      m_tdata  = '0;
      m_tlast  = 1'b1;
      m_tuser  = 2'b10;
    end else begin
      m_tvalid = pass & in_valid;
      m_tdata  = in_data;
      m_tlast  = in_last;
      m_tuser  = {1'b0, state_q == PK_IDLE};
    end
  end
endmodule

// File: rtl/rx_enable_ctrl.sv
module rx_enable_ctrl
  import rxctl_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                TDATA_W  = 32,
  parameter int                NUM_FIFO = 3,
  parameter int                PCFG_W   = 8,
  parameter logic [PCFG_W-1:0] PCFG_RST = 8'h10,
  parameter int                IER_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                short_full_i,
  input  logic                line_full_i,
  output logic                lane_shutdown_o,
  output logic [NUM_FIFO-1:0] flush_o,
  input  logic                in_valid,
  input  logic [TDATA_W-1:0]  in_data,
  input  logic                in_last,
  output logic                in_ready,
  output logic                m_tvalid,
  output logic [TDATA_W-1:0]  m_tdata,
  output logic                m_tlast,
  output logic [1:0]          m_tuser,
  input  logic                m_tready
);
  logic              rst_meta_q, rst_sync_q;
  logic              rst_sync_n;
  logic [STAT_W-1:0] stat_sync;
  logic              run_en;
  logic              soft_rst;
  logic              halt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_sync_n = rst_sync_q;

  rxctl_sync #(.WIDTH(STAT_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({line_full_i, short_full_i}),
    .q     (stat_sync)
  );

  rxctl_regs #(
    .ADDR_W   (ADDR_W),
    .PCFG_W   (PCFG_W),
    .PCFG_RST (PCFG_RST),
    .IER_W    (IER_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .stat     (stat_sync),
    .run_en   (run_en),
    .soft_rst (soft_rst)
  );

  assign halt            = ~run_en | soft_rst;
  assign lane_shutdown_o = ~run_en;

  rxctl_flush #(.NUM_FIFO(NUM_FIFO)) u_flush (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .halt  (halt),
    .flush (flush_o)
  );

  rxctl_pkt #(.TDATA_W(TDATA_W)) u_pkt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .halt     (halt),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .m_tvalid (m_tvalid),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .m_tuser  (m_tuser),
    .m_tready (m_tready)
  );
endmodule

// File: rtl/rx_enable_ctrl_chk.sv
module rx_enable_ctrl_chk #(
  parameter int ADDR_W   = 8,
  parameter int TDATA_W  = 32,
  parameter int NUM_FIFO = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [31:0]         reg_wdata,
  input logic                lane_shutdown_o,
  input logic [NUM_FIFO-1:0] flush_o,
  input logic                in_ready,
  input logic                m_tvalid,
  input logic [TDATA_W-1:0]  m_tdata,
  input logic                m_tlast,
  input logic [1:0]          m_tuser,
  input logic                m_tready,
  input logic                short_full_i,
  input logic                line_full_i,
  input logic [1:0]          stat_sync
);
  logic [1:0] cyc_q;
  logic       cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd2)  cyc_q <= cyc_q + 2'd1;
  end

  assign cfg_wr = reg_wr_en && (reg_addr == '0);

  // R6: shutdown follows the written enable bit
  p_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (lane_shutdown_o == !$past(reg_wdata[0])));

  // R7: flush strobe lasts one cycle
  p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_o) |=> !(|flush_o));

  // R8: error beat closes the packet with zero data
  p_close_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tuser[1]) |-> (m_tlast && (m_tdata == '0)));

  // R8: error beat held while stalled
  p_close_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tuser[1] && !m_tready) |=> (m_tvalid && m_tuser[1]));

  // R9: halting write blocks input in the next cycle
  p_halt_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (reg_wdata[1] || !reg_wdata[0])) |=> !in_ready);

  // R11: two-edge status synchronizer
  p_sync_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd2) |-> (stat_sync == {$past(line_full_i, 2), $past(short_full_i, 2)}));
endmodule

bind rx_enable_ctrl rx_enable_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .TDATA_W  (TDATA_W),
  .NUM_FIFO (NUM_FIFO)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .reg_wr_en       (reg_wr_en),
  .reg_addr        (reg_addr),
  .reg_wdata       (reg_wdata),
  .lane_shutdown_o (lane_shutdown_o),
  .flush_o         (flush_o),
  .in_ready        (in_ready),
  .m_tvalid        (m_tvalid),
  .m_tdata         (m_tdata),
  .m_tlast         (m_tlast),
  .m_tuser         (m_tuser),
  .m_tready        (m_tready),
  .short_full_i    (short_full_i),
  .line_full_i     (line_full_i),
  .stat_sync       (stat_sync)
);

// File: tb/rx_enable_ctrl_test.sv
`timescale 1ns/1ps
module rx_enable_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        short_full_i, line_full_i;
  logic        lane_shutdown_o;
  logic [2:0]  flush_o;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_last;
  logic        in_ready;
  logic        m_tvalid;
  logic [31:0] m_tdata;
  logic        m_tlast;
  logic [1:0]  m_tuser;
  logic        m_tready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  rx_enable_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .short_full_i(short_full_i),
    .line_full_i(line_full_i), .lane_shutdown_o(lane_shutdown_o), .flush_o(flush_o),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tuser(m_tuser),
    .m_tready(m_tready)
  );

  // {offset, write data, expected read-back}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hFFFF_FFFD, 32'h0000_0001},  // R3
    {8'h04, 32'hFFFF_FFFE, 32'h0000_0002},  // R2
    {8'h08, 32'h0000_01A5, 32'h0000_00A5},  // R2
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0001},  // R2
    {8'h28, 32'hFFFF_FFFF, 32'h0000_0003},  // R2
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},  // R12
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 read-only
    {8'h04, 32'h0000_0001, 32'h0000_0001}   // R2
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    short_full_i = 1'b0; line_full_i = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; m_tready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    reg_read(8'h00, rd); chk("R1 cfg", rd, 32'h1);
    reg_read(8'h04, rd); chk("R1 lanes", rd, 32'h0);
    tick();
    reg_read(8'h08, rd); chk("R1 pcfg", rd, 32'h10);
    reg_read(8'h20, rd); chk("R1 gie", rd, 32'h0);
    tick();
    reg_read(8'h28, rd); chk("R1 ier", rd, 32'h0);
    chk("R1 shutdown", {31'd0, lane_shutdown_o}, 32'h0);
    chk("R1 flush", {29'd0, flush_o}, 32'h0);
    chk("R1 tvalid", {31'd0, m_tvalid}, 32'h0);

    // R2 R3 R12 register table
    for (int i = 0; i < 8; i++) begin
      reg_write(VEC[i][71:64], VEC[i][63:32]);
      reg_read(VEC[i][71:64], rd);
      chk($sformatf("R2/R3/R12 vec %0d", i), rd, VEC[i][31:0]);
    end

    // R10 pass-through, first beat flagged
    tick();
    in_valid = 1'b1; in_data = 32'hAAAA_0001; in_last = 1'b0; m_tready = 1'b1;
    #0.2;
    chk("R10 fwd valid", {31'd0, m_tvalid}, 32'h1);
    chk("R10 first user", {30'd0, m_tuser}, 32'h1);
    chk("R10 data", m_tdata, 32'hAAAA_0001);
    chk("R10 ready", {31'd0, in_ready}, 32'h1);
    tick();
    in_data = 32'hAAAA_0002;
    m_tready = 1'b0;
    #0.2;
    chk("R10 stall ready", {31'd0, in_ready}, 32'h0);
    m_tready = 1'b1;
    #0.2;
    chk("R10 later user", {30'd0, m_tuser}, 32'h0);
    tick();
    in_valid = 1'b0;

    // R8 abort with soft reset; R6 no shutdown; R7 flush
    m_tready = 1'b0;
    reg_write(8'h00, 32'h3);
    chk("R7 flush on soft reset", {29'd0, flush_o}, 32'h7);
    chk("R6 soft reset no shutdown", {31'd0, lane_shutdown_o}, 32'h0);
    chk("R9 no fwd before close", {31'd0, m_tvalid}, 32'h0);
    tick();
    chk("R7 flush one cycle", {29'd0, flush_o}, 32'h0);
    chk("R8 close valid", {31'd0, m_tvalid}, 32'h1);
    chk("R8 close last", {31'd0, m_tlast}, 32'h1);
    chk("R8 close user", {30'd0, m_tuser}, 32'h2);
    chk("R8 close data", m_tdata, 32'h0);
    tick();
    chk("R8 close held", {31'd0, m_tvalid & m_tuser[1]}, 32'h1);
    m_tready = 1'b1;
    tick();
    chk("R8 single close beat", {31'd0, m_tvalid}, 32'h0);

    // R9 halted input blocked
    in_valid = 1'b1; in_data = 32'hBBBB_0001; in_last = 1'b0;
    #0.2;
    chk("R9 in_ready halted", {31'd0, in_ready}, 32'h0);
    chk("R9 no fwd halted", {31'd0, m_tvalid}, 32'h0);

    // R4 soft reset holds defaults, preserves the rest
    reg_read(8'h08, rd); chk("R4 pcfg default", rd, 32'h10);
    reg_read(8'h04, rd); chk("R4 lanes kept", rd, 32'h1);
    tick();
    reg_read(8'h20, rd); chk("R4 gie kept", rd, 32'h1);
    reg_read(8'h28, rd); chk("R4 ier kept", rd, 32'h3);
    tick();
    reg_read(8'h00, rd); chk("R4 cfg kept", rd, 32'h3);
    reg_write(8'h08, 32'h77);
    reg_read(8'h08, rd); chk("R4 pcfg write ignored", rd, 32'h10);
    reg_write(8'h04, 32'h2);
    reg_read(8'h04, rd); chk("R4 lanes writable", rd, 32'h2);

    // R5 release
    reg_write(8'h00, 32'h1);
    chk("R5 input accepted", {31'd0, in_ready}, 32'h1);
    chk("R5 forwarded", {31'd0, m_tvalid}, 32'h1);
    tick();
    in_last = 1'b1;
    tick();
    in_valid = 1'b0; in_last = 1'b0;
    reg_write(8'h08, 32'h33);
    reg_read(8'h08, rd); chk("R5 pcfg writable", rd, 32'h33);

    // R6 R7 R13 disable while idle
    reg_write(8'h00, 32'h0);
    chk("R6 shutdown on disable", {31'd0, lane_shutdown_o}, 32'h1);
    chk("R7 flush on disable", {29'd0, flush_o}, 32'h7);
    tick();
    chk("R13 no close beat", {31'd0, m_tvalid}, 32'h0);
    reg_write(8'h00, 32'h2);
    chk("R7 no flush when halted", {29'd0, flush_o}, 32'h0);
    chk("R6 shutdown held", {31'd0, lane_shutdown_o}, 32'h1);
    reg_write(8'h00, 32'h1);
    chk("R6 shutdown released", {31'd0, lane_shutdown_o}, 32'h0);

    // R11 status synchronizer
    short_full_i = 1'b1;
    tick();
    reg_read(8'h10, rd); chk("R11 after one edge", rd, 32'h0);
    tick();
    reg_read(8'h10, rd); chk("R11 short after two edges", rd, 32'h1);
    line_full_i = 1'b1; short_full_i = 1'b0;
    tick(); tick();
    reg_read(8'h10, rd); chk("R11 line bit", rd, 32'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule